// File: doc/BRIEF.md
# Wake-up External Interrupt Controller

This block watches a set of asynchronous wake-up input lines and turns the events on them into interrupt requests. Each input is first brought into the clock domain through a short synchroniser chain. A trigger mode chosen by software then decides whether the line fires on a level or on an edge. A line that fires latches a pending bit. Pending bits that are not masked are ORed into a small number of parent interrupt outputs, and each parent covers a fixed, uneven range of lines.

Software uses a flat word-wide register port. Two configuration words hold the 4-bit trigger selectors. A mask word blocks lines from the parent outputs, and a pending word is read to find the source and written with ones to acknowledge it. Lines are configured in pairs: neighbouring lines 2k and 2k+1 share one selector. The parent interrupt handler reads pending and mask and works out which line to service.

Top module: `wake_irq_ctrl`

## Requirements
- R1: Selector code 0 fires on a low synchronised level, 1 on a high level, 2 on a falling edge, 4 on a rising edge and 6 on both edges. An input change driven before rising edge A shows in the pending word after the third rising edge counted from A (two synchroniser flops, then the pending register).
- R2: Line n takes its selector from configuration word n/16 (register address 0 for lines 0–15, address 1 for lines 16–27), at bits 4*((n mod 16)/2) to 4*((n mod 16)/2)+3. Lines 2k and 2k+1 therefore always share one mode.
- R3: Selector codes 3, 5, 7 and 8–15 never set a pending bit, whatever the input does.
- R4: A mask bit of 1 (mask word, address 2, bit n for line n) keeps line n off its parent output but does not stop the line from setting its pending bit. A mask bit of 0 lets the line through.
- R5: A write to the pending word (address 3) clears each bit written as 1 and leaves each bit written as 0 unchanged. If a line fires in the same cycle as the clear, its pending bit stays set. A line held at its active level in a level mode sets its pending bit again on every cycle, so a clear takes effect only once the level goes away.
- R6: irq_o[0] is the OR of pending-and-unmasked over lines 0–3, irq_o[1] over lines 4–11, irq_o[2] over lines 12–19 and irq_o[3] over lines 20–27.
- R7: While reset is held, the configuration words read 0, the mask reads all ones (0x0FFFFFFF), the pending word reads 0 and every irq_o bit is 0.
- R8: rd_data returns, without delay, the register chosen by rd_addr (0 and 1 for the configuration words, 2 for mask, 3 for pending). Bits above line 27 read as 0 in the mask and pending words. A write takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 28 | Asynchronous wake-up lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data |
| irq_o | output | 4 | Parent interrupt outputs |

## Verification
The bench builds the block with its default parameters: 28 lines, four parents and a two-stage synchroniser. At these values both configuration words are in use, and so are the short first parent range and the three eight-line ranges, including the top range that reaches line 27. Directed patterns load every legal and illegal selector code at once, so edge, level and dead pairs run side by side. Random input and register traffic then mixes clears that land together with events, level lines that stay active, and changes of mask, all compared cycle by cycle with a reference model.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;

  localparam int unsigned SEL_W         = 4;
  localparam int unsigned LINES_PER_CFG = 16;
  localparam int unsigned REG_ADDR_W    = 2;
  localparam int unsigned DATA_W        = 32;

  localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PEND = 2'd3;

  typedef enum logic [SEL_W-1:0] {
    TRIG_LVL_LO = 4'd0,
    TRIG_LVL_HI = 4'd1,
    TRIG_FALL   = 4'd2,
    TRIG_RISE   = 4'd4,
    TRIG_BOTH   = 4'd6
  } trig_e;

  // Parent index of a line: first parent spans four lines, the rest eight.
  function automatic int unsigned parent_of(int unsigned line);
    return (line < 4) ? 0 : ((line - 4) / 8) + 1;
  endfunction

  function automatic logic code_ok(logic [SEL_W-1:0] code);
    case (code)
      TRIG_LVL_LO, TRIG_LVL_HI, TRIG_FALL, TRIG_RISE, TRIG_BOTH: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned WIDTH  = 28,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = din;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
    end
  end

  assign dout = chain_q[STAGES-1];

  // Cycles-since-reset tracker for the latency check.
  logic [STAGES-1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= (warm_q << 1) | {{(STAGES-1){1'b0}}, 1'b1};
  end

  assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q[STAGES-1] |-> (dout == $past(din, STAGES)));

endmodule

// File: rtl/wake_trig_detect.sv
module wake_trig_detect
  import wake_irq_pkg::*;
#(
  parameter int unsigned LINES = 28
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LINES-1:0]       sync_i,
  input  logic [LINES*SEL_W-1:0] sel_i,
  output logic [LINES-1:0]       hit_o
);

  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] prev_d;

  assign prev_d = sync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [SEL_W-1:0] code;
    logic             now, was;
    assign code = sel_i[i*SEL_W +: SEL_W];
    assign now  = sync_i[i];
    assign was  = prev_q[i];

    always_comb begin
      case (code)
        TRIG_LVL_LO: hit_o[i] = ~now;
        TRIG_LVL_HI: hit_o[i] = now;
        TRIG_FALL:   hit_o[i] = was & ~now;
        TRIG_RISE:   hit_o[i] = ~was & now;
        TRIG_BOTH:   hit_o[i] = was ^ now;
        default:     hit_o[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/wake_irq_agg.sv
module wake_irq_agg
  import wake_irq_pkg::*;
#(
  parameter int unsigned LINES   = 28,
  parameter int unsigned PARENTS = 4
) (
  input  logic [LINES-1:0]   pend_i,
  input  logic [LINES-1:0]   mask_i,
  output logic [PARENTS-1:0] irq_o
);

  logic [LINES-1:0] live;
  assign live = pend_i & ~mask_i;

  always_comb begin
    irq_o = '0;
    for (int unsigned j = 0; j < LINES; j++) begin
      if (parent_of(j) < PARENTS) irq_o[parent_of(j)] = irq_o[parent_of(j)] | live[j];
    end
  end

endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wake_irq_pkg::*;
#(
  parameter int unsigned LINES       = 28,
  parameter int unsigned PARENTS     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINES-1:0]      wake_i,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic [PARENTS-1:0]    irq_o
);

  localparam int unsigned CFG_WORDS = (LINES + LINES_PER_CFG - 1) / LINES_PER_CFG;

  logic [DATA_W-1:0] cfg_q [CFG_WORDS];
  logic [DATA_W-1:0] cfg_d [CFG_WORDS];
  logic [LINES-1:0]  mask_q, mask_d;
  logic [LINES-1:0]  pend_q, pend_d;
  logic [LINES-1:0]  sync_vec, hit_vec, clr_vec;
  logic [LINES*SEL_W-1:0] sel_flat;
  logic              mask_we, pend_we;

  // Write decode
  assign mask_we = wr_en && (wr_addr == ADDR_MASK);
  assign pend_we = wr_en && (wr_addr == ADDR_PEND);
  assign clr_vec = pend_we ? wr_data[LINES-1:0] : '0;

  // Selector fan-out: a pair of lines shares one field
  for (genvar n = 0; n < LINES; n++) begin : g_sel
    localparam int unsigned WORD = n / LINES_PER_CFG;
    localparam int unsigned POS  = SEL_W * ((n % LINES_PER_CFG) / 2);
    assign sel_flat[n*SEL_W +: SEL_W] = cfg_q[WORD][POS +: SEL_W];
  end

  wake_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (wake_i),
    .dout (sync_vec)
  );

  wake_trig_detect #(.LINES(LINES)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .sync_i(sync_vec),
    .sel_i (sel_flat),
    .hit_o (hit_vec)
  );

  wake_irq_agg #(.LINES(LINES), .PARENTS(PARENTS)) u_agg (
    .pend_i(pend_q),
    .mask_i(mask_q),
    .irq_o (irq_o)
  );

  // Next state
  always_comb begin
    for (int unsigned w = 0; w < CFG_WORDS; w++) begin
      cfg_d[w] = (wr_en && (wr_addr == REG_ADDR_W'(w))) ? wr_data : cfg_q[w];
    end
    mask_d = mask_we ? wr_data[LINES-1:0] : mask_q;
    pend_d = (pend_q & ~clr_vec) | hit_vec;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned w = 0; w < CFG_WORDS; w++) cfg_q[w] <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      for (int unsigned w = 0; w < CFG_WORDS; w++) cfg_q[w] <= cfg_d[w];
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  // Read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_MASK)      rd_data[LINES-1:0] = mask_q;
    else if (rd_addr == ADDR_PEND) rd_data[LINES-1:0] = pend_q;
    else begin
      for (int unsigned w = 0; w < CFG_WORDS; w++) begin
        if (rd_addr == REG_ADDR_W'(w)) rd_data = cfg_q[w];
      end
    end
  end

  // A bit written as 1 ends up equal to the detector's verdict of that cycle.
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we |=> ((pend_q & $past(clr_vec)) == ($past(hit_vec) & $past(clr_vec))));

  // No pending bit falls unless a clearing write named it.
  assert_no_lost_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0));

  for (genvar n = 0; n < LINES; n++) begin : g_chk
    assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[n]) |-> $past(code_ok(sel_flat[n*SEL_W +: SEL_W])));
  end

endmodule

// File: tb/wake_irq_ctrl_tb.sv
module wake_irq_ctrl_tb;

  localparam int N = 28;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] wake_i;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic [3:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wake_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  // Reference model state
  logic [N-1:0] m_s1, m_s2, m_prev, m_pend, m_mask;
  logic [31:0]  m_cfg0, m_cfg1;

  function automatic logic [N-1:0] f_hit(logic [N-1:0] s, logic [N-1:0] p,
                                         logic [31:0] c0, logic [31:0] c1);
    logic [N-1:0] h;
    for (int i = 0; i < N; i++) begin
      logic [3:0] c;
      c = (i < 16) ? c0[4*(i/2) +: 4] : c1[4*((i-16)/2) +: 4];
      case (c)
        4'd0: h[i] = !s[i];
        4'd1: h[i] = s[i];
        4'd2: h[i] = p[i] && !s[i];
        4'd4: h[i] = !p[i] && s[i];
        4'd6: h[i] = p[i] != s[i];
        default: h[i] = 1'b0;
      endcase
    end
    return h;
  endfunction

  function automatic logic [3:0] f_irq(logic [N-1:0] pd, logic [N-1:0] mk);
    logic [N-1:0] a;
    a = pd & ~mk;
    return {|(a & 28'hFF00000), |(a & 28'h00FF000), |(a & 28'h0000FF0), |(a & 28'h000000F)};
  endfunction

  function automatic logic [31:0] f_rd(logic [1:0] a);
    case (a)
      2'd0: return m_cfg0;
      2'd1: return m_cfg1;
      2'd2: return {4'h0, m_mask};
      default: return {4'h0, m_pend};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_mask = '1;
    m_cfg0 = '0; m_cfg1 = '0;
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge.
  task automatic step(logic [N-1:0] w, logic we, logic [1:0] wa, logic [31:0] wd,
                      logic [1:0] ra, string tag);
    logic [N-1:0] h, clr;
    wake_i = w; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    h      = f_hit(m_s2, m_prev, m_cfg0, m_cfg1);
    clr    = (we && wa == 2'd3) ? wd[N-1:0] : '0;
    m_pend = (m_pend & ~clr) | h;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = w;
    if (we) begin
      case (wa)
        2'd0: m_cfg0 = wd;
        2'd1: m_cfg1 = wd;
        2'd2: m_mask = wd[N-1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    check({tag, " irq (R6)"}, {28'h0, irq_o}, {28'h0, f_irq(m_pend, m_mask)});
    check({tag, " rd (R8)"}, rd_data, f_rd(ra));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] w;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; wake_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      check("R7 reset reg", rd_data, (a == 2) ? 32'h0FFF_FFFF : 32'h0);
    end
    check("R7 reset irq", {28'h0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Mask lines all masked: levels latch pending but irq stays low (R4)
    step('0, 0, 0, 0, 2'd3, "R4 masked-latch");
    step('0, 0, 0, 0, 2'd3, "R4 masked-latch");
    // Load mixed selectors: pairs 0..7 = rise,fall,both,high,3,5,7,F (R2,R3)
    step('0, 1, 2'd0, 32'hF753_1624, 2'd0, "R2 cfg0");
    step('0, 1, 2'd1, 32'h0000_0642, 2'd1, "R2 cfg1");
    step('0, 1, 2'd2, 32'h0, 2'd2, "R4 unmask");
    step('0, 1, 2'd3, 32'hFFFF_FFFF, 2'd3, "R5 clear all");
    for (int k = 0; k < 5; k++) step('0, 0, 0, 0, 2'd3, "R1 idle");
    // Rising edge on all lines; pending appears three edges later (R1)
    for (int k = 0; k < 5; k++) step('1, 0, 0, 0, 2'd3, "R1 rise");
    step('1, 1, 2'd3, 32'hFFFF_FFFF, 2'd3, "R5 clear vs level");
    step('1, 0, 0, 0, 2'd3, "R5 level reasserts");
    for (int k = 0; k < 5; k++) step('0, 0, 0, 0, 2'd3, "R1 fall");
    step('0, 1, 2'd3, 32'h0000_00C0, 2'd3, "R5 partial clear");
    step('0, 1, 2'd3, 32'h0000_0000, 2'd3, "R5 zero write");
    // Single-line toggles: one line of a pair follows its partner's mode (R2)
    for (int i = 0; i < N; i++) begin
      w = '0; w[i] = 1'b1;
      step('0, 1, 2'd3, 32'hFFFF_FFFF, 2'd3, "R2 clr");
      for (int k = 0; k < 3; k++) step(w, 0, 0, 0, 2'd3, "R2 single");
      for (int k = 0; k < 3; k++) step('0, 0, 0, 0, 2'd3, "R3 single back");
    end
    // Range isolation: unmask one parent range at a time (R6)
    step('1, 1, 2'd0, 32'h1111_1111, 2'd0, "R6 all high-level");
    step('1, 1, 2'd1, 32'h1111_1111, 2'd1, "R6 all high-level");
    for (int k = 0; k < 4; k++) step('1, 0, 0, 0, 2'd3, "R6 settle");
    step('1, 1, 2'd2, 32'h0FFF_FFF0, 2'd2, "R6 range0");
    step('1, 1, 2'd2, 32'h0FFF_F00F, 2'd2, "R6 range1");
    step('1, 1, 2'd2, 32'h0FF0_0FFF, 2'd2, "R6 range2");
    step('1, 1, 2'd2, 32'h000F_FFFF, 2'd2, "R6 range3");
    step('1, 1, 2'd2, 32'h0FFF_FFFF, 2'd2, "R4 all masked");

    // Random phase
    w = '0;
    for (int k = 0; k < 3000; k++) begin
      logic        we;
      logic [1:0]  wa;
      logic [31:0] wd;
      w  = w ^ (N'($urandom()) & N'($urandom()) & N'($urandom()));
      we = ($urandom_range(0, 5) == 0);
      wa = 2'($urandom_range(0, 3));
      wd = $urandom();
      step(w, we, wa, wd, 2'($urandom_range(0, 3)), "R1 R3 R5 random");
    end
    wr_en = 1'b0;
    done = 1'b1;
    finish_run();
  end

endmodule